// File: doc/BRIEF.md
# Single-Error-Correcting RAM with Built-In Self-Test

This block puts a Hamming code with an extra overall parity bit around a generic synchronous single-port memory. Every stored word carries check bits that are computed as it is written. Every word read back is decoded. A single flipped bit anywhere in the stored codeword is repaired before the data reaches the port. A two-bit upset is reported as uncorrectable. Each read returns two flags with the data: one for a repaired error and one for an uncorrectable error.

A self-test engine can take over the memory. It writes an address-dependent pattern into every location and then reads every location back twice. The second read of each address has one codeword bit deliberately inverted on its way into the decoder, so the run also proves that the correction path works. The test starts on a pulse at an input pin or on a control-register command. While it runs, normal requests are dropped. At the end it gives a one-cycle strobe and sets sticky done and pass outputs.

A small register port also exposes the status. It holds a codeword injection mask that is XORed into every normal write, and it gives read-back of the last encoded codeword, so the encoder can be checked in normal operation.

Top module: `ecc_ram_bist`

## Requirements
- R1: A normal write stores a 22-bit codeword for 16-bit data. Data bits 0..15 occupy codeword positions 3,5,6,7,9..15,17..21 in ascending order. The parity bit at position 2^k (k=0..4) makes even the parity of all positions whose index has bit k set. Bit 0 makes even the parity of the whole codeword. The codeword before injection is readable at register select 2 after the write.
- R2: A read request accepted at a clock edge gives rd_valid high in the next cycle, with the stored data on rd_data. If the codeword is clean, both error flags are low.
- R3: Register select 1 holds an injection mask that is XORed into the codeword of every normal write while it is set. With exactly one mask bit set, at any position 0..21, the read returns the original data with rd_corr_err=1 and rd_uncorr_err=0.
- R4: With two mask bits set, the read gives rd_uncorr_err=1 and rd_corr_err=0. The two flags are never high together.
- R5: The self-test starts on bist_start high at an idle edge, or on a register write to select 0 with bit 0 set. bist_busy is high from the next cycle. A start request while busy neither restarts nor ends the run.
- R6: While bist_busy is high, normal requests are ignored. No rd_valid is produced and no write reaches the memory.
- R7: The end of a run is marked by bist_end high for exactly one cycle. In the following cycle bist_busy is low and bist_done is high. bist_done and bist_pass are cleared when the next run starts.
- R8: The self-test writes pattern bit i = addr[i mod 5] XOR (i mod 2) into every address. On a healthy memory it sets bist_pass=1. The pattern stays in memory after the run.
- R9: Each address is read twice during the check phase: once clean and expecting no flag, and once with one forced bit flip expecting a correction. bist_busy stays high for exactly 5*DEPTH+1 cycles (161 for 32 words).
- R10: Register select 0 reads {pass, done, busy} in bits 2..0. Select 3 reads zero. After reset all status, flags, mask and last-codeword values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Normal access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Word address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Corrected read data |
| rd_corr_err | output | 1 | Single-bit error repaired on this read |
| rd_uncorr_err | output | 1 | Uncorrectable error on this read |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 22 | Register write data |
| reg_rdata | output | 22 | Register read data (combinational) |
| bist_start | input | 1 | Self-test launch pulse |
| bist_busy | output | 1 | Self-test running |
| bist_end | output | 1 | One-cycle completion strobe |
| bist_done | output | 1 | Sticky: a run has completed |
| bist_pass | output | 1 | Sticky: last run found no fault |

## Verification
The codeword path is tried with all-zero, all-one, alternating and walking-one data words. The register read-back shows whether each parity bit and data bit sits at the position R1 gives it. Single-bit injection is walked over all 22 positions, covering data bits, check bits and the overall parity bit. This tells a repair at the right position apart from a repair at the wrong one, and from a flag that is raised without the data being repaired. Double-bit masks show that detection is separate from correction. The self-test is launched from the pin and from the register. During a run, writes, reads and a second start pulse are applied. The memory is then swept to tell whether those blocked writes leaked through and whether every address holds its own pattern.

// File: rtl/ecc_ram_pkg.sv
`timescale 1ns/1ps
// Package: shared helpers and types for the protected RAM.
// Assumes positive widths; parity count follows the Hamming bound.
package ecc_ram_pkg;

    // Smallest parity count p with 2^p >= data + p + 1.
    function automatic int par_bits(input int data_w);
        int p;
        p = 1;
        while ((1 << p) < (data_w + p + 1)) p++;
        return p;
    endfunction

    // True when v (>0) is a power of two, i.e. a check-bit position.
    function automatic logic is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_ISSUE,
        ST_RD_CHECK,
        ST_FL_ISSUE,
        ST_FL_CHECK,
        ST_FINISH
    } bist_state_e;

endpackage

// File: rtl/ecc_ram_enc.sv
`timescale 1ns/1ps
// Encoder: builds an extended Hamming codeword from a data word.
// Position 0 holds overall parity, positions 2^k hold check bits,
// data fills the remaining positions in ascending order. Purely combinational.
module ecc_ram_enc #(
    parameter int DATA_W = 16,
    localparam int PAR_W = ecc_ram_pkg::par_bits(DATA_W),
    localparam int CW_W  = DATA_W + PAR_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);
    import ecc_ram_pkg::*;

    // Spread data, then compute check bits and overall parity.
    always_comb begin
        logic [CW_W-1:0] cw;
        int   k;
        logic acc;
        cw = '0;
        k  = 0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (!is_pow2(pos)) begin
                cw[pos] = data_i[k];
                k++;
            end
        end
        for (int b = 0; b < PAR_W; b++) begin
            acc = 1'b0;
            for (int pos = 1; pos < CW_W; pos++) begin
                if (((pos >> b) & 1) == 1 && !is_pow2(pos)) acc ^= cw[pos];
            end
            cw[1 << b] = acc;
        end
        cw[0] = ^cw[CW_W-1:1];
        cw_o  = cw;
    end

endmodule

// File: rtl/ecc_ram_dec.sv
`timescale 1ns/1ps
// Decoder: computes syndrome and overall parity of a codeword, repairs a
// single flipped bit and flags double errors. Purely combinational.
// Assumes the layout produced by ecc_ram_enc.
module ecc_ram_dec #(
    parameter int DATA_W = 16,
    localparam int PAR_W = ecc_ram_pkg::par_bits(DATA_W),
    localparam int CW_W  = DATA_W + PAR_W + 1
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o,
    output logic              uncorr_o
);
    import ecc_ram_pkg::*;

    logic [PAR_W-1:0] syn;
    logic             odd;
    logic             fixable;

    // Syndrome is the XOR of the indices of all set bits.
    always_comb begin
        syn = '0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (cw_i[pos]) syn ^= PAR_W'(pos);
        end
        odd = ^cw_i;
    end

    // Classify: odd weight with an in-range syndrome is one repairable flip.
    always_comb begin
        fixable  = odd && (int'(syn) < CW_W);
        corr_o   = fixable;
        uncorr_o = (!odd && (syn != '0)) || (odd && (int'(syn) >= CW_W));
    end

    // Extract data, inverting the bit the syndrome points at.
    always_comb begin
        int k;
        k = 0;
        data_o = '0;
        for (int pos = 1; pos < CW_W; pos++) begin
            if (!is_pow2(pos)) begin
                data_o[k] = cw_i[pos] ^ (fixable && (int'(syn) == pos));
                k++;
            end
        end
    end

endmodule

// File: rtl/ecc_ram_array.sv
`timescale 1ns/1ps
// Generic synchronous single-port memory, one-cycle read latency.
// Contents are not reset; read data holds until the next read.
module ecc_ram_array #(
    parameter int WORD_W = 22,
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Write or read one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) mem[addr_i] <= wdata_i;
            else      rdata_o     <= mem[addr_i];
        end
    end

endmodule

// File: rtl/ecc_ram_bist_ctl.sv
`timescale 1ns/1ps
// Self-test sequencer: writes an address-keyed pattern to every word,
// then per address does a clean read and a read with one forced bit flip
// at the decoder input. Any mismatch clears the pass result.
// Assumes the memory has one-cycle read latency and the decoder is combinational.
module ecc_ram_bist_ctl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    parameter int CW_W   = 22,
    localparam int FLIP_W = $clog2(CW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              end_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              ram_en_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [CW_W-1:0]   flip_o,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic              dec_corr_i,
    input  logic              dec_uncorr_i
);
    import ecc_ram_pkg::*;

    bist_state_e        state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [FLIP_W-1:0]  flip_q;
    logic               fail_q;
    logic               done_q;
    logic               pass_q;
    logic [DATA_W-1:0]  pat;
    logic               last_addr;
    logic               chk_ok;

    // Pattern bit i = address bit (i mod ADDR_W) inverted on odd i.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            pat[i] = addr_q[i % ADDR_W] ^ ((i % 2) == 1);
        end
    end

    // Forced single-bit flip only in the second-read check cycle.
    always_comb begin
        for (int b = 0; b < CW_W; b++) begin
            flip_o[b] = (state_q == ST_FL_CHECK) && (flip_q == FLIP_W'(b));
        end
    end

    // Compare decoder output against the expectation for this phase.
    always_comb begin
        if (state_q == ST_FL_CHECK)
            chk_ok = (dec_data_i == pat) && dec_corr_i && !dec_uncorr_i;
        else
            chk_ok = (dec_data_i == pat) && !dec_corr_i && !dec_uncorr_i;
    end

    assign last_addr  = &addr_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign end_o      = (state_q == ST_FINISH);
    assign done_o     = done_q;
    assign pass_o     = pass_q;
    assign ram_en_o   = (state_q == ST_WRITE) || (state_q == ST_RD_ISSUE)
                        || (state_q == ST_FL_ISSUE);
    assign ram_we_o   = (state_q == ST_WRITE);
    assign ram_addr_o = addr_q;
    assign wdata_o    = pat;

    // Sequence the write sweep, the double read sweep and the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            flip_q  <= '0;
            fail_q  <= 1'b0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_WRITE;
                        addr_q  <= '0;
                        flip_q  <= '0;
                        fail_q  <= 1'b0;
                        done_q  <= 1'b0;
                        pass_q  <= 1'b0;
                    end
                end
                ST_WRITE: begin
                    addr_q <= addr_q + 1'b1;
                    if (last_addr) state_q <= ST_RD_ISSUE;
                end
                ST_RD_ISSUE: state_q <= ST_RD_CHECK;
                ST_RD_CHECK: begin
                    if (!chk_ok) fail_q <= 1'b1;
                    state_q <= ST_FL_ISSUE;
                end
                ST_FL_ISSUE: state_q <= ST_FL_CHECK;
                ST_FL_CHECK: begin
                    if (!chk_ok) fail_q <= 1'b1;
                    flip_q <= (flip_q == FLIP_W'(CW_W - 1)) ? '0 : flip_q + 1'b1;
                    addr_q <= addr_q + 1'b1;
                    state_q <= last_addr ? ST_FINISH : ST_RD_ISSUE;
                end
                ST_FINISH: begin
                    done_q  <= 1'b1;
                    pass_q  <= !fail_q;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_END_RELEASES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (!busy_o && done_o)); // R7
    AST_END_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> !end_o); // R7
    AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !end_o) |=> busy_o); // R5
    AST_FLIP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip_o)); // R9

endmodule

// File: rtl/ecc_ram_bist.sv
`timescale 1ns/1ps
// Top: Hamming-protected single-port RAM with self-test and a small
// register port (status, write injection mask, last encoded codeword).
// Assumes one request per cycle; requests are dropped while self-test runs.
module ecc_ram_bist #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    localparam int PAR_W = ecc_ram_pkg::par_bits(DATA_W),
    localparam int CW_W  = DATA_W + PAR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_corr_err,
    output logic              rd_uncorr_err,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [CW_W-1:0]   reg_wdata,
    output logic [CW_W-1:0]   reg_rdata,
    input  logic              bist_start,
    output logic              bist_busy,
    output logic              bist_end,
    output logic              bist_done,
    output logic              bist_pass
);
    logic              start_req;
    logic              host_acc;
    logic              rd_valid_q;
    logic [CW_W-1:0]   inj_mask_q;
    logic [CW_W-1:0]   last_cw_q;
    logic              b_en, b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wdata;
    logic [CW_W-1:0]   b_flip;
    logic [DATA_W-1:0] enc_in;
    logic [CW_W-1:0]   enc_cw;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [CW_W-1:0]   ram_wdata, ram_rdata;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr, dec_uncorr;

    assign start_req = bist_start || (reg_wr && (reg_sel == 2'd0) && reg_wdata[0]);
    assign host_acc  = req_valid && !bist_busy;

    ecc_ram_bist_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CW_W(CW_W)) ctl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_req),
        .busy_o(bist_busy), .end_o(bist_end), .done_o(bist_done), .pass_o(bist_pass),
        .ram_en_o(b_en), .ram_we_o(b_we), .ram_addr_o(b_addr), .wdata_o(b_wdata),
        .flip_o(b_flip), .dec_data_i(dec_data), .dec_corr_i(dec_corr),
        .dec_uncorr_i(dec_uncorr)
    );

    // One shared encoder: self-test owns it while busy.
    assign enc_in = bist_busy ? b_wdata : req_wdata;

    ecc_ram_enc #(.DATA_W(DATA_W)) enc_i (.data_i(enc_in), .cw_o(enc_cw));

    // Memory port mux between host and self-test; mask hits host writes only.
    always_comb begin
        if (bist_busy) begin
            ram_en    = b_en;
            ram_we    = b_we;
            ram_addr  = b_addr;
            ram_wdata = enc_cw;
        end else begin
            ram_en    = host_acc;
            ram_we    = req_we;
            ram_addr  = req_addr;
            ram_wdata = enc_cw ^ inj_mask_q;
        end
    end

    ecc_ram_array #(.WORD_W(CW_W), .ADDR_W(ADDR_W)) mem_i (
        .clk(clk), .en_i(ram_en), .we_i(ram_we), .addr_i(ram_addr),
        .wdata_i(ram_wdata), .rdata_o(ram_rdata)
    );

    ecc_ram_dec #(.DATA_W(DATA_W)) dec_i (
        .cw_i(ram_rdata ^ b_flip), .data_o(dec_data),
        .corr_o(dec_corr), .uncorr_o(dec_uncorr)
    );

    // Track read latency, injection mask and last encoded host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            inj_mask_q <= '0;
            last_cw_q  <= '0;
        end else begin
            rd_valid_q <= host_acc && !req_we;
            if (reg_wr && (reg_sel == 2'd1)) inj_mask_q <= reg_wdata;
            if (host_acc && req_we) last_cw_q <= enc_cw;
        end
    end

    assign rd_valid      = rd_valid_q;
    assign rd_data       = dec_data;
    assign rd_corr_err   = rd_valid_q && dec_corr;
    assign rd_uncorr_err = rd_valid_q && dec_uncorr;

    // Register read mux.
    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = CW_W'({bist_pass, bist_done, bist_busy});
            2'd1:    reg_rdata = inj_mask_q;
            2'd2:    reg_rdata = last_cw_q;
            default: reg_rdata = '0;
        endcase
    end

    AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bist_busy |=> !rd_valid); // R6
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_we && !bist_busy) |=> rd_valid); // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corr_err && rd_uncorr_err)); // R4
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        bist_pass |-> bist_done); // R8

endmodule

// File: tb/ecc_ram_bist_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module ecc_ram_bist_tb_top;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int CW = 22;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid, rd_corr_err, rd_uncorr_err;
    logic [DW-1:0] rd_data;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [CW-1:0] reg_wdata = '0;
    logic [CW-1:0] reg_rdata;
    logic          bist_start = 1'b0;
    logic          bist_busy, bist_end, bist_done, bist_pass;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ecc_ram_bist dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_corr_err(rd_corr_err), .rd_uncorr_err(rd_uncorr_err),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bist_start(bist_start), .bist_busy(bist_busy), .bist_end(bist_end),
        .bist_done(bist_done), .bist_pass(bist_pass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference codeword built from the R1 layout.
    function automatic logic [CW-1:0] ref_cw(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int k;
        logic par;
        c = '0;
        k = 0;
        for (int p = 1; p < CW; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                c[p] = d[k];
                k = k + 1;
            end
        end
        for (int b = 0; b < 5; b++) begin
            par = 1'b0;
            for (int p = 1; p < CW; p++)
                if ((p & (1 << b)) != 0 && p != (1 << b)) par ^= c[p];
            c[1 << b] = par;
        end
        c[0] = ^c[CW-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] ref_pat(input int a);
        logic [DW-1:0] v;
        for (int i = 0; i < DW; i++) v[i] = ((a >> (i % AW)) & 1) ^ (i % 2);
        return v;
    endfunction

    task automatic host_write(input int a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic host_read(input int a);
        req_valid = 1'b1; req_we = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [CW-1:0] v);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [CW-1:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [CW-1:0] v;
        chk("R10 busy after reset", 32'(bist_busy), 0);
        chk("R10 done after reset", 32'(bist_done), 0);
        chk("R10 pass after reset", 32'(bist_pass), 0);
        chk("R10 rd_valid after reset", 32'(rd_valid), 0);
        reg_read(2'd0, v); chk("R10 status reg after reset", 32'(v), 0);
        reg_read(2'd1, v); chk("R10 mask reg after reset", 32'(v), 0);
        reg_read(2'd2, v); chk("R10 last codeword after reset", 32'(v), 0);
    endtask

    task automatic t_encode();
        logic [DW-1:0] pats [6];
        logic [CW-1:0] v;
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hAAAA;
        pats[3] = 16'h5555; pats[4] = 16'h0001; pats[5] = 16'h8000;
        foreach (pats[i]) begin
            host_write(i, pats[i]);
            reg_read(2'd2, v);
            chk("R1 encoded codeword", 32'(v), 32'(ref_cw(pats[i])));
        end
        for (int b = 0; b < DW; b++) begin
            host_write(8 + (b % 8), DW'(1) << b);
            reg_read(2'd2, v);
            chk("R1 walking-one codeword", 32'(v), 32'(ref_cw(DW'(1) << b)));
        end
        reg_read(2'd3, v);
        chk("R10 select 3 reads zero", 32'(v), 0);
    endtask

    task automatic t_clean_rw();
        logic [DW-1:0] d;
        for (int a = 0; a < 6; a++) begin
            d = DW'(16'h1357 * (a + 3)) ^ DW'(a << 11);
            host_write(16 + a, d);
        end
        for (int a = 0; a < 6; a++) begin
            d = DW'(16'h1357 * (a + 3)) ^ DW'(a << 11);
            host_read(16 + a);
            chk("R2 rd_valid", 32'(rd_valid), 1);
            chk("R2 read data", 32'(rd_data), 32'(d));
            chk("R2 no flags clean", 32'({rd_corr_err, rd_uncorr_err}), 0);
        end
        @(negedge clk);
        chk("R2 rd_valid drops without request", 32'(rd_valid), 0);
    endtask

    task automatic t_single();
        logic [CW-1:0] v;
        for (int p = 0; p < CW; p++) begin
            reg_write(2'd1, CW'(1) << p);
            host_write(p % WORDS, 16'hC3A5 ^ DW'(p));
            reg_write(2'd1, '0);
            host_read(p % WORDS);
            chk("R3 corrected data", 32'(rd_data), 32'(16'hC3A5 ^ DW'(p)));
            chk("R3 corr flag", 32'(rd_corr_err), 1);
            chk("R3 uncorr flag low", 32'(rd_uncorr_err), 0);
        end
        reg_write(2'd1, 22'h00_0808);
        reg_read(2'd1, v);
        chk("R3 mask read back", 32'(v), 32'h0000_0808);
        reg_write(2'd1, '0);
    endtask

    task automatic t_double();
        logic [CW-1:0] masks [3];
        masks[0] = (CW'(1) << 3) | (CW'(1) << 10);
        masks[1] = (CW'(1) << 0) | (CW'(1) << 5);
        masks[2] = (CW'(1) << 4) | (CW'(1) << 21);
        foreach (masks[i]) begin
            reg_write(2'd1, masks[i]);
            host_write(20 + i, 16'h0F0F);
            reg_write(2'd1, '0);
            host_read(20 + i);
            chk("R4 uncorr flag", 32'(rd_uncorr_err), 1);
            chk("R4 corr flag low on double", 32'(rd_corr_err), 0);
        end
    endtask

    // Runs until busy falls; with_traffic adds blocked requests and a restart pulse.
    task automatic run_bist(input bit use_pin, input bit with_traffic);
        int cnt;
        bit saw_end;
        logic [CW-1:0] v;
        cnt = 0;
        saw_end = 0;
        if (use_pin) begin
            bist_start = 1'b1;
            @(negedge clk);
            bist_start = 1'b0;
        end else begin
            reg_write(2'd0, 22'h1);
        end
        chk("R5 busy after start", 32'(bist_busy), 1);
        reg_read(2'd0, v);
        chk("R10 status while busy", 32'(v), 32'h1);
        chk("R7 done cleared on start", 32'(bist_done), 0);
        while (bist_busy && cnt < 1000) begin
            cnt++;
            if (bist_end) saw_end = 1;
            if (with_traffic) begin
                if (cnt == 40) begin
                    req_valid = 1'b1; req_we = 1'b1; req_addr = 5'd3; req_wdata = 16'hDEAD;
                end
                if (cnt == 41) begin
                    req_we = 1'b0; req_addr = 5'd3;
                end
                if (cnt == 42) begin
                    req_valid = 1'b0;
                    chk("R6 no rd_valid while busy", 32'(rd_valid), 0);
                end
                if (cnt == 50) bist_start = 1'b1;
                if (cnt == 51) bist_start = 1'b0;
            end
            @(negedge clk);
        end
        chk("R9 busy duration 5*DEPTH+1", 32'(cnt), 32'(5 * WORDS + 1));
        chk("R7 end strobe seen", 32'(saw_end), 1);
        chk("R7 end strobe single cycle", 32'(bist_end), 0);
        chk("R7 done sticky", 32'(bist_done), 1);
        chk("R8 pass", 32'(bist_pass), 1);
        reg_read(2'd0, v);
        chk("R10 status after run", 32'(v), 32'h6);
    endtask

    task automatic t_bist_pin();
        run_bist(1'b1, 1'b1);
        for (int a = 0; a < WORDS; a++) begin
            host_read(a);
            if (a == 3) chk("R6 blocked write left pattern", 32'(rd_data), 32'(ref_pat(a)));
            else        chk("R8 pattern in memory", 32'(rd_data), 32'(ref_pat(a)));
            chk("R8 pattern reads clean", 32'({rd_corr_err, rd_uncorr_err}), 0);
        end
    endtask

    task automatic t_bist_reg();
        host_write(7, 16'h1234);
        run_bist(1'b0, 1'b0);
        host_read(7);
        chk("R8 run overwrote host data", 32'(rd_data), 32'(ref_pat(7)));
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encode();
        t_clean_rw();
        t_single();
        t_double();
        t_bist_pin();
        t_bist_reg();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule